// File: doc/BRIEF.md
# DRAM Off-Page Read Sequencer

This block drives the control strobes and the multiplexed address bus of a page-mode DRAM for one normal (off-page) read. A request carries a flat address. The block presents the row half of the address, precharges with RAS high, drops RAS, then switches the bus to the column half and drops CAS and the output enable. A one-tick capture strobe marks the clock in which the read data must be latched, and a one-tick done pulse ends the cycle. Three configuration fields each add whole bus clocks of waiting: one to the precharge, one to the row hold and one to the data access. An external wait input can stretch the data access further, one bus clock for each sample it is seen high.

The sequencer runs on a clock at twice the bus rate, so every strobe edge falls on a half-bus-clock boundary. In this text one "tick" means one sequencer clock, which is half a bus clock. The first sequencer edge that accepts a request is a rising bus edge. Even tick boundaries counted from that edge are therefore rising bus edges, and odd boundaries are falling ones. A write request does not run a DRAM cycle here. The block hands it on with a start pulse, and when the previous operation was a read it first inserts a configurable number of idle bus clocks.

Top module: `dram_rdseq`

## Requirements
- R1: During and right after reset, ras_n, cas_n and oe_n are high, and cap_stb, done and wr_start are low.
- R2: A read request is accepted in the idle state. With tick 0 being the first tick after the accepting edge and p = cfg_rp, ras_n stays high for ticks 0 to 2p and is low from tick 2p+1.
- R3: dram_addr carries the row, which is the upper MA_W bits of req_addr, while col_sel is low. col_sel goes high, and the bus switches to the column (the lower MA_W bits), at tick 2p+2r+2, where r = cfg_rh. This gives 1+2r ticks of row hold after RAS falls.
- R4: cas_n falls at tick 2p+2r+3, one tick after the column appears. It stays low for exactly 2+2d+2w ticks, where d = cfg_da and w is the number of wait extensions.
- R5: bus_wait is sampled at the sequencer edge that ends tick 2p+2r+2d+2, which is a falling bus edge. Each sample that finds it high adds 2 ticks and schedules a new sample at the edge 2 ticks later. The first sample that finds it low ends the wait extensions.
- R6: ras_n stays low for exactly 5+2r+2d+2w ticks and is high again at tick 2p+2r+2d+2w+6. The whole cycle is 2(3+p+r+d+w) ticks.
- R7: oe_n goes low in the same tick as cas_n and returns high one tick after cas_n, in the same tick as ras_n.
- R8: cap_stb is high for exactly one tick per read. That tick is the last CAS-low tick, 2p+2r+2d+2w+4, and it begins on a rising bus edge.
- R9: done is high for exactly one tick per read, at tick 2p+2r+2d+2w+5, and the block is idle with RAS high in the following tick.
- R10: For a write request whose previous operation was a read, with i = cfg_idle, wr_start pulses at tick 2i after the accepting edge (tick 0 when i = 0). ras_n, cas_n and oe_n stay high throughout.
- R11: For a write request after reset or after another write, wr_start pulses in tick 0 with no idle ticks.
- R12: cfg_rp, cfg_rh, cfg_da and cfg_idle are taken at the accepting edge. Changing them during a cycle has no effect on that cycle's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted while idle |
| req_write | input | 1 | 1 = write hand-off, 0 = off-page read |
| req_addr | input | 2*MA_W | Flat address: row in upper half, column in lower half |
| cfg_rp | input | WAIT_W | Precharge wait, in bus clocks |
| cfg_rh | input | WAIT_W | Row hold wait, in bus clocks |
| cfg_da | input | WAIT_W | Data access wait, in bus clocks |
| cfg_idle | input | IDLE_W | Idle bus clocks before a write that follows a read |
| bus_wait | input | 1 | External wait request, active high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| col_sel | output | 1 | Address mux select: 1 = column on dram_addr |
| dram_addr | output | MA_W | Multiplexed DRAM address |
| cap_stb | output | 1 | Read data capture tick |
| done | output | 1 | Read cycle complete |
| wr_start | output | 1 | Write hand-off pulse |

## Verification
When cfg_da is zero, the falling edge of CAS and the first sample of bus_wait occur at the same sequencer edge. The next state at that edge must then both start the column strobe and decide whether to extend it. The bench sweeps every combination of the three wait fields, including all cases with a zero data-access field, and pairs them with zero, one and two external waits. It drives bus_wait from its own tick count so that the signal is high exactly for the first w samples. The CAS-low width, the capture tick and the RAS rise tick are then compared with the arithmetic formulas. A one-tick error in where the sample falls changes all three.

// File: rtl/dram_rdseq_pkg.sv
package dram_rdseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ROWH, S_COLS, S_DA, S_WT, S_LAST, S_POST, S_IDLW, S_WRGO
  } seq_state_e;
endpackage

// File: rtl/dram_rdseq_timer.sv
module dram_rdseq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_en   = load_en || !cnt_zero;

  always_comb begin
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dram_rdseq_ctrl.sv
module dram_rdseq_ctrl
  import dram_rdseq_pkg::*;
#(
  parameter int WAIT_W = 2,
  parameter int IDLE_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WAIT_W-1:0] cfg_rp,
  input  logic [WAIT_W-1:0] cfg_rh,
  input  logic [WAIT_W-1:0] cfg_da,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              bus_wait,
  input  logic              cnt_zero,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val,
  output logic              accept,
  output seq_state_e        state_q
);
  seq_state_e        state_d;
  logic [WAIT_W-1:0] rh_q, rh_d, da_q, da_d;
  logic              last_rd_q, last_rd_d;
  seq_state_e        wait_pick;

  // Wait sample point: one more bus clock if bus_wait is high, else the last one.
  assign wait_pick = bus_wait ? S_WT : S_LAST;

  always_comb begin
    state_d   = state_q;
    rh_d      = rh_q;
    da_d      = da_q;
    last_rd_d = last_rd_q;
    load_en   = 1'b0;
    load_val  = '0;
    accept    = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        accept  = 1'b1;
        load_en = 1'b1;
        if (!req_write) begin
          state_d  = S_PRE;
          load_val = CNT_W'({cfg_rp, 1'b0});
          rh_d     = cfg_rh;
          da_d     = cfg_da;
        end else if (last_rd_q && (cfg_idle != '0)) begin
          state_d  = S_IDLW;
          load_val = CNT_W'({cfg_idle, 1'b0}) - CNT_W'(1);
        end else begin
          state_d  = S_WRGO;
        end
      end
      S_PRE: if (cnt_zero) begin
        state_d  = S_ROWH;
        load_en  = 1'b1;
        load_val = CNT_W'({rh_q, 1'b0});
      end
      S_ROWH: if (cnt_zero) begin
        state_d = S_COLS;
        load_en = 1'b1;
      end
      S_COLS: begin
        load_en = 1'b1;
        if (da_q != '0) begin
          state_d  = S_DA;
          load_val = CNT_W'({da_q, 1'b0}) - CNT_W'(1);
        end else begin
          state_d  = wait_pick;
          load_val = CNT_W'(1);
        end
      end
      S_DA, S_WT: if (cnt_zero) begin
        state_d  = wait_pick;
        load_en  = 1'b1;
        load_val = CNT_W'(1);
      end
      S_LAST: if (cnt_zero) begin
        state_d = S_POST;
        load_en = 1'b1;
      end
      S_POST: begin
        state_d   = S_IDLE;
        last_rd_d = 1'b1;
      end
      S_IDLW: if (cnt_zero) begin
        state_d = S_WRGO;
        load_en = 1'b1;
      end
      S_WRGO: begin
        state_d   = S_IDLE;
        last_rd_d = 1'b0;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rh_q      <= '0;
      da_q      <= '0;
      last_rd_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rh_q      <= rh_d;
      da_q      <= da_d;
      last_rd_q <= last_rd_d;
    end
  end
endmodule

// File: rtl/dram_rdseq_amux.sv
module dram_rdseq_amux #(
  parameter int MA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic              col_sel,
  output logic [MA_W-1:0]   dram_addr
);
  logic [2*MA_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= req_addr;
  end

  assign dram_addr = col_sel ? addr_q[MA_W-1:0] : addr_q[2*MA_W-1:MA_W];
endmodule

// File: rtl/dram_rdseq.sv
module dram_rdseq
  import dram_rdseq_pkg::*;
#(
  parameter int MA_W   = 10,
  parameter int WAIT_W = 2,
  parameter int IDLE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [WAIT_W-1:0] cfg_rp,
  input  logic [WAIT_W-1:0] cfg_rh,
  input  logic [WAIT_W-1:0] cfg_da,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              bus_wait,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              col_sel,
  output logic [MA_W-1:0]   dram_addr,
  output logic              cap_stb,
  output logic              done,
  output logic              wr_start
);
  localparam int CNT_W = ((WAIT_W > IDLE_W) ? WAIT_W : IDLE_W) + 2;

  seq_state_e       state_q;
  logic             load_en, accept, cnt_zero;
  logic [CNT_W-1:0] load_val;

  dram_rdseq_ctrl #(.WAIT_W(WAIT_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cfg_rp(cfg_rp), .cfg_rh(cfg_rh), .cfg_da(cfg_da), .cfg_idle(cfg_idle),
    .bus_wait(bus_wait), .cnt_zero(cnt_zero), .load_en(load_en),
    .load_val(load_val), .accept(accept), .state_q(state_q)
  );

  dram_rdseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .cnt_zero(cnt_zero)
  );

  dram_rdseq_amux #(.MA_W(MA_W)) u_amux (
    .clk(clk), .rst_n(rst_n), .capture(accept), .req_addr(req_addr),
    .col_sel(col_sel), .dram_addr(dram_addr)
  );

  always_comb begin
    ras_n = !(state_q inside {S_ROWH, S_COLS, S_DA, S_WT, S_LAST, S_POST});
    cas_n = !(state_q inside {S_DA, S_WT, S_LAST});
    oe_n  = !(state_q inside {S_DA, S_WT, S_LAST, S_POST});
    col_sel  = state_q inside {S_COLS, S_DA, S_WT, S_LAST, S_POST};
    cap_stb  = (state_q == S_LAST) && cnt_zero;
    done     = (state_q == S_POST);
    wr_start = (state_q == S_WRGO);
  end
endmodule

// File: rtl/dram_rdseq_chk.sv
module dram_rdseq_chk #(
  parameter int MA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            oe_n,
  input logic            col_sel,
  input logic [MA_W-1:0] dram_addr,
  input logic            cap_stb,
  input logic            done,
  input logic            wr_start
);
  // R4
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R4
  col_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(col_sel));
  // R3
  row_on_ras_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !col_sel);
  // R3
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !col_sel) |-> $stable(dram_addr));
  // R7
  oe_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ras_n);
  // R8
  cap_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> !cas_n);
  // R9
  cap_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> done);
  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ras_n);
  // R10
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (ras_n && cas_n && oe_n));
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_stb, done, wr_start}));
endmodule

bind dram_rdseq dram_rdseq_chk #(.MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .col_sel(col_sel), .dram_addr(dram_addr), .cap_stb(cap_stb), .done(done),
  .wr_start(wr_start)
);

// File: tb/dram_rdseq_tb.sv
`timescale 1ns/1ps
module dram_rdseq_tb;
  localparam int MA_W = 10;
  localparam int WAIT_W = 2;
  localparam int IDLE_W = 2;

  logic clk = 1'b0;
  logic rst_n, req_valid, req_write, bus_wait;
  logic [2*MA_W-1:0] req_addr;
  logic [WAIT_W-1:0] cfg_rp, cfg_rh, cfg_da;
  logic [IDLE_W-1:0] cfg_idle;
  logic ras_n, cas_n, oe_n, col_sel, cap_stb, done, wr_start;
  logic [MA_W-1:0] dram_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dram_rdseq #(.MA_W(MA_W), .WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .cfg_rp(cfg_rp), .cfg_rh(cfg_rh), .cfg_da(cfg_da),
    .cfg_idle(cfg_idle), .bus_wait(bus_wait), .ras_n(ras_n), .cas_n(cas_n),
    .oe_n(oe_n), .col_sel(col_sel), .dram_addr(dram_addr), .cap_stb(cap_stb),
    .done(done), .wr_start(wr_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk({tag, " ras_n"}, ras_n, 1);
    chk({tag, " cas_n"}, cas_n, 1);
    chk({tag, " oe_n"}, oe_n, 1);
    chk({tag, " pulses"}, {cap_stb, done, wr_start}, 0);
  endtask

  task automatic do_read(input int p, input int r, input int d, input int w);
    int ras_first = -1, ras_cnt = 0, cas_first = -1, cas_cnt = 0;
    int oe_first = -1, oe_cnt = 0, col_first = -1, cap_tick = -1;
    int cap_cnt = 0, done_tick = -1, row_seen = -1, col_seen = -1;
    int ras_back = 0;
    logic [MA_W-1:0] row_v, col_v;
    row_v = MA_W'(p * 64 + r * 16 + d * 4 + w + 5);
    col_v = MA_W'(~(p * 37 + r * 11 + d * 3 + w));
    @(negedge clk);
    cfg_rp = WAIT_W'(p); cfg_rh = WAIT_W'(r); cfg_da = WAIT_W'(d);
    req_addr = {row_v, col_v};
    req_valid = 1'b1; req_write = 1'b0; bus_wait = 1'b0;
    @(posedge clk);
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      req_valid = 1'b0;
      // R12: scramble the configuration once the cycle has been accepted
      cfg_rp = ~WAIT_W'(p); cfg_rh = ~WAIT_W'(r); cfg_da = ~WAIT_W'(d);
      // R5: high exactly for the first w samples
      bus_wait = (j < 2*p + 2*r + 2*d + 2*w + 2);
      if (j == 0) row_seen = int'(dram_addr);
      if (!ras_n) begin ras_cnt++; if (ras_first < 0) ras_first = j; end
      if (!cas_n) begin cas_cnt++; if (cas_first < 0) cas_first = j; end
      if (!oe_n) begin oe_cnt++; if (oe_first < 0) oe_first = j; end
      if (col_sel && col_first < 0) begin col_first = j; col_seen = int'(dram_addr); end
      if (cap_stb) begin cap_cnt++; cap_tick = j; end
      if (done) begin done_tick = j; break; end
    end
    @(negedge clk);
    bus_wait = 1'b0;
    ras_back = ras_n;
    chk("R2 ras fall tick", ras_first, 2*p + 1);
    chk("R3 row address", row_seen, int'(row_v));
    chk("R3 column select tick", col_first, 2*p + 2*r + 2);
    chk("R3 column address", col_seen, int'(col_v));
    chk("R4 cas fall tick", cas_first, 2*p + 2*r + 3);
    chk("R4 R5 cas low width", cas_cnt, 2 + 2*d + 2*w);
    chk("R6 ras low width", ras_cnt, 5 + 2*r + 2*d + 2*w);
    chk("R6 ras high after cycle", ras_back, 1);
    chk("R7 oe fall tick", oe_first, 2*p + 2*r + 3);
    chk("R7 oe low width", oe_cnt, 3 + 2*d + 2*w);
    chk("R8 capture tick", cap_tick, 2*p + 2*r + 2*d + 2*w + 4);
    chk("R8 capture count", cap_cnt, 1);
    chk("R9 done tick", done_tick, 2*p + 2*r + 2*d + 2*w + 5);
  endtask

  task automatic do_write(input int i, input int exp_tick, input string tag);
    int go_tick = -1;
    int quiet = 1;
    @(negedge clk);
    cfg_idle = IDLE_W'(i);
    req_valid = 1'b1; req_write = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 50; j++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_idle = ~IDLE_W'(i); // R12
      if (!ras_n || !cas_n || !oe_n) quiet = 0;
      if (wr_start) begin go_tick = j; break; end
    end
    chk({tag, " wr_start tick"}, go_tick, exp_tick);
    chk({tag, " strobes quiet"}, quiet, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; bus_wait = 1'b0;
    req_addr = '0; cfg_rp = '0; cfg_rh = '0; cfg_da = '0; cfg_idle = '0;
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_outputs("R1 after reset");

    do_write(3, 0, "R11 first write");
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 4; d++) begin
          int w = (p + d + r) % 3;
          int i = (p + r) % 4;
          do_read(p, r, d, w);
          do_write(i, 2*i, "R10 write after read");
          do_write((i + 1) % 4, 0, "R11 write after write");
        end
    repeat (2) @(negedge clk);
    idle_outputs("R9 final idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule